// File: doc/BRIEF.md
# CRC-32 Frame Residue Checker

This block runs a reflected CRC-32 over a byte-serial stream, one byte for each valid cycle. Each frame is a message followed by its 4-byte CRC. The running value is exposed so the same engine can also generate a CRC for outgoing data. On the receive side the appended CRC is not captured. Its four bytes go through the same engine straight after the message, and the frame is judged good when the final register holds a fixed non-zero constant.

A frame begins with the byte that carries the start marker and ends with the byte that carries the end marker. One cycle after the end byte, a completion pulse is raised and a pass flag is sampled. The flag then holds until the next frame starts. The generator is 0x04C11DB7, processed LSB-first as 0xEDB88320, and the register is seeded with 0xFFFFFFFF.

Top module: `crc_residue_chk`

## Requirements
- R1: After reset, crc_o reads 0x00000000 (the inverse of the 0xFFFFFFFF seed), and done_o and ok_o are 0.
- R2: A valid byte with sof_i high is absorbed starting from the 0xFFFFFFFF seed, whatever the register held before.
- R3: Each valid byte is absorbed LSB-first with reflected polynomial 0xEDB88320. crc_o is the bitwise inverse of the register, visible the cycle after the byte. The bytes "123456789" give 0xCBF43926.
- R4: While valid_i is low, the register, crc_o and done_o are unaffected, and byte_i, sof_i and eof_i are ignored.
- R5: done_o is high for exactly the one cycle after each valid byte that has eof_i high, and is low otherwise.
- R6: ok_o is 1 after a frame whose message is followed by its CRC (crc_o value sent least significant byte first), because the register then equals 0xDEBB20E3.
- R7: ok_o is 0 after a frame in which any single bit of the message or of the appended CRC is inverted.
- R8: ok_o keeps its value until the next valid byte with sof_i high. That byte clears it, unless the same byte also carries eof_i.
- R9: A frame of one byte, with sof_i and eof_i on the same valid byte, is seeded, absorbed and judged in that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Data byte |
| valid_i | input | 1 | byte_i holds a byte to absorb |
| sof_i | input | 1 | This byte opens a frame |
| eof_i | input | 1 | This byte closes a frame |
| crc_o | output | 32 | Inverted running CRC register |
| done_o | output | 1 | One-cycle pulse after the closing byte |
| ok_o | output | 1 | Frame residue matched, held until the next frame |

## Verification
The bench sweeps every single-byte frame. A wrong polynomial, a wrong bit order or a missing seed on the start byte would show up as a wrong crc_o on at least one of the 256 values. Good frames of lengths 1 to 8 are sent with idle gaps that carry stray markers. A design that absorbs bytes while valid is low, or pulses done on an unqualified end marker, would either fail the residue or pulse at the wrong time. Every single-bit flip in a 10-byte frame must clear the pass flag; a residue compare of the wrong width or against the wrong constant would let some of them through. The bench also checks that the flag survives idle cycles and is cleared by a restarting frame.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned W    = 32,
  parameter int unsigned DW   = 8,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] data_i,
  output logic [W-1:0]  crc_o
);
  localparam int unsigned PAD = W - DW;

  logic [DW:0][W-1:0] stg;

  assign stg[0] = crc_i ^ {{PAD{1'b0}}, data_i};

  // one shift/xor stage per input bit, LSB first
  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign stg[g+1] = stg[g][0] ? ((stg[g] >> 1) ^ POLY) : (stg[g] >> 1);
  end

  assign crc_o = stg[DW];
endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sof_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] seed_o,
  output logic [W-1:0] crc_q_o
);
  logic [W-1:0] crc_q;

  assign seed_o  = sof_i ? INIT : crc_q;
  assign crc_q_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (valid_i) crc_q <= next_i;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q)); // R4
endmodule

// File: rtl/crc_verdict.sv
module crc_verdict #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] RESIDUE = 32'hDEBB20E3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sof_i,
  input  logic         eof_i,
  input  logic [W-1:0] next_i,
  output logic         done_o,
  output logic         ok_o
);
  logic close_w;
  assign close_w = valid_i & eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      done_o <= close_w;
      if (close_w)              ok_o <= (next_i == RESIDUE);
      else if (valid_i & sof_i) ok_o <= 1'b0;
    end
  end

  AST_OK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i & (sof_i | eof_i)) |=> $stable(ok_o)); // R8
  AST_SOF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i & sof_i & !eof_i) |=> !ok_o); // R8
  AST_OK_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> done_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_w |=> !done_o); // R5
endmodule

// File: rtl/crc_residue_chk.sv
module crc_residue_chk
  import crc_chk_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320,
  parameter logic [CRC_W-1:0] INIT      = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] RESIDUE   = 32'hDEBB20E3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              ok_o
);
  crc_t seed_w, next_w, crc_q;

  crc_state_reg #(.W(CRC_W), .INIT(INIT)) u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .next_i(next_w), .seed_o(seed_w), .crc_q_o(crc_q)
  );

  crc_byte_step #(.W(CRC_W), .DW(BYTE_W), .POLY(POLY_REFL)) u_step (
    .crc_i(seed_w), .data_i(byte_i), .crc_o(next_w)
  );

  crc_verdict #(.W(CRC_W), .RESIDUE(RESIDUE)) u_verdict (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sof_i(sof_i),
    .eof_i(eof_i), .next_i(next_w), .done_o(done_o), .ok_o(ok_o)
  );

  assign crc_o = ~crc_q;

  AST_CLOSE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i & eof_i) |=> done_o); // R5
  AST_SOF_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i & sof_i & (byte_i == 8'h00)) |=> (crc_o == 32'hD202EF8D)); // R2
endmodule

// File: tb/crc_residue_chk_tb.sv
module crc_residue_chk_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        valid_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0;
  logic [31:0] crc_o;
  logic        done_o, ok_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] frm [0:15];

  always #10 clk_i = ~clk_i;

  crc_residue_chk u_dut (.*);

  function automatic logic [31:0] upd(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // inputs set just after a negedge, sampled at the posedge, result visible at next negedge
  task automatic put(logic [7:0] b, logic v, logic s, logic e);
    byte_i = b; valid_i = v; sof_i = s; eof_i = e;
    @(negedge clk_i);
  endtask

  // sends frm[0:n-1]; gap inserts an idle cycle with stray markers after each byte
  task automatic send(int n, bit gap);
    for (int i = 0; i < n; i++) begin
      put(frm[i], 1'b1, i == 0, i == n - 1);
      if (gap && i != n - 1) begin
        logic [31:0] hold;
        hold = crc_o;
        put(8'hA5, 1'b0, 1'b1, 1'b1);
        chk("R4 idle crc", crc_o, hold);
        chk("R4 idle done", {31'h0, done_o}, 32'h0);
      end
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) c = upd(c, frm[i]);
    return c;
  endfunction

  task automatic append(int n);
    logic [31:0] c;
    c = ~ref_crc(n);
    for (int k = 0; k < 4; k++) frm[n + k] = c[8*k +: 8];
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 crc", crc_o, 32'h0);
    chk("R1 done", {31'h0, done_o}, 32'h0);
    chk("R1 ok", {31'h0, ok_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9, R3: every single-byte frame
    for (int b = 0; b < 256; b++) begin
      logic [31:0] r;
      r = upd(32'hFFFFFFFF, b[7:0]);
      put(b[7:0], 1'b1, 1'b1, 1'b1);
      chk("R9 crc", crc_o, ~r);
      chk("R5 done", {31'h0, done_o}, 32'h1);
      chk("R9 ok", {31'h0, ok_o}, {31'h0, r == 32'hDEBB20E3});
    end
    put(8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5 done low", {31'h0, done_o}, 32'h0);

    // R2: partial frame abandoned, then a check string
    for (int i = 0; i < 3; i++) frm[i] = 8'h5A + i[7:0];
    send(3, 0);
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + i[7:0];
    send(9, 0);
    chk("R3 R2 check value", crc_o, 32'hCBF43926);

    // R6 with gaps (R4)
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < n; i++) frm[i] = 8'(n * 37 + i * 11 + 3);
      append(n);
      send(n + 4, n[0]);
      chk("R6 done", {31'h0, done_o}, 32'h1);
      chk("R6 ok", {31'h0, ok_o}, 32'h1);
    end

    // R8: hold through idle, including stray markers with valid low
    for (int i = 0; i < 4; i++) begin
      put(8'hFF, 1'b0, 1'b1, i[0]);
      chk("R8 hold", {31'h0, ok_o}, 32'h1);
      chk("R5 no pulse", {31'h0, done_o}, 32'h0);
    end
    put(8'h10, 1'b1, 1'b0, 1'b0);
    chk("R8 mid byte no sof", {31'h0, ok_o}, 32'h1);
    put(8'h10, 1'b1, 1'b1, 1'b0);
    chk("R8 cleared by sof", {31'h0, ok_o}, 32'h0);

    // R7: every single-bit flip in a 10-byte frame
    for (int bit_idx = 0; bit_idx < 80; bit_idx++) begin
      for (int i = 0; i < 6; i++) frm[i] = 8'(i * 29 + 7);
      append(6);
      frm[bit_idx / 8][bit_idx % 8] = ~frm[bit_idx / 8][bit_idx % 8];
      send(10, 0);
      chk("R7 ok", {31'h0, ok_o}, 32'h0);
    end
    for (int i = 0; i < 6; i++) frm[i] = 8'(i * 29 + 7);
    append(6);
    send(10, 0);
    chk("R6 clean frame", {31'h0, ok_o}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule